// File: doc/BRIEF.md
# Comma-Framed PRBS7 Link Tester

This block is a link-test pair for a 32-bit parallel transceiver path that has already been decoded. The generator half emits a framing word that carries one K28.5 comma character. It follows that word with payload words filled from a PRBS7 sequence, and it repeats the framing word at a fixed spacing. The checker half watches the received words and their control-character flags. It waits for a comma and takes its prediction seed from the first payload word after that comma. From then on it compares every payload word against its own running PRBS7 copy.

The checker drives a single pass flag. The flag rises only after a run of consecutive clean payload words, and any bad word drops it. If the receive sync indication falls, as it does during a link outage or a rate change with a PHY reset, the checker drops the flag and goes back to comma search. It locks again once sync returns. In normal use the transmit outputs drive the transceiver's parallel input, and the receive inputs come from the transceiver's decoded output.

Top module: `prbs_link_tester`

## Requirements
- R1: A framing word has control flags 4'b0001 and data 32'h000000BC: K28.5 sits in byte lane 0 and the other three lanes are zero.
- R2: The first word sent after reset is a framing word. A framing word then follows every FRAME_LEN words, and it is always followed by at least one payload word.
- R3: Payload words carry control flags 4'b0000 and 32 PRBS7 bits (x^7 + x^6 + 1, generator state starting at SEED, bit 31 sent first). The sequence does not advance during framing words, so the payload continues across them without a gap.
- R4: While reset is high, and in the cycle after it, tx_data, tx_ctrl and test_pass are all zero.
- R5: After sync, the checker ignores the data until it sees a framing word. It takes the low 7 bits of the next payload word as its prediction seed, and it does not compare that seed word.
- R6: test_pass rises on the clock edge that consumes the PASS_RUN-th consecutive matching payload word after the seed word, and not before.
- R7: A single mismatching payload word clears test_pass on the edge that consumes it and restarts the run count. The prediction continues, so PASS_RUN further clean words raise test_pass again.
- R8: A framing word that arrives while the checker is locked is not compared, does not advance the prediction and does not change test_pass.
- R9: With rx_sync low, test_pass is cleared on the next edge and the checker returns to comma search. When rx_sync returns, the checker relocks by way of R5 and R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_data | output | 32 | Generated word toward the transceiver |
| tx_ctrl | output | 4 | Control-character flag per byte lane of tx_data |
| rx_data | input | 32 | Decoded received word |
| rx_ctrl | input | 4 | Control-character flag per byte lane of rx_data |
| rx_sync | input | 1 | Receive sync status from the PHY |
| test_pass | output | 1 | High while the received stream has been clean for PASS_RUN words |

## Verification
The bench builds the block with FRAME_LEN = 24 and PASS_RUN = 16. With these values a frame holds 23 payload words, so the comma, the seed word and the full run of 16 fit between two framing words. Every lock sequence can therefore be counted word by word to its exact edge. The short frame also puts framing words inside every locked stretch, which exercises the skip behaviour many times. Error bits, error timing and sync-drop lengths are drawn at random with a fixed seed, and each lock attempt is checked against an exact word count.

// File: rtl/prbs_link_pkg.sv
package prbs_link_pkg;

  localparam logic [7:0] K28_5 = 8'hBC;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_SEED  = 2'd1,
    ST_CHECK = 2'd2
  } chk_state_t;

  // Produce 32 PRBS7 bits (x^7 + x^6 + 1) from state s, first bit in bit 31.
  // The next state equals the low 7 bits of the returned word.
  function automatic logic [31:0] prbs7_word32(input logic [6:0] s);
    logic [6:0]  r;
    logic [31:0] w;
    logic        b;
    r = s;
    w = '0;
    for (int i = 0; i < 32; i++) begin
      b = r[6] ^ r[5];
      r = {r[5:0], b};
      w[31 - i] = b;
    end
    return w;
  endfunction

endpackage

// File: rtl/prbs_frame_gen.sv
module prbs_frame_gen
  import prbs_link_pkg::*;
#(
  parameter int         FRAME_LEN = 64,
  parameter logic [6:0] SEED      = 7'h7F
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] tx_data,
  output logic [3:0]  tx_ctrl
);

  localparam int CNT_W = (FRAME_LEN > 2) ? $clog2(FRAME_LEN) : 1;

  logic [CNT_W-1:0] pos_q;
  logic [6:0]       lfsr_q;
  logic [31:0]      word_c;

  assign word_c = prbs7_word32(lfsr_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q   <= '0;
      lfsr_q  <= SEED;
      tx_data <= '0;
      tx_ctrl <= '0;
    end else begin
      if (pos_q == CNT_W'(FRAME_LEN - 1)) pos_q <= '0;
      else                                pos_q <= pos_q + 1'b1;
      if (pos_q == '0) begin
        tx_data <= {24'h0, K28_5};
        tx_ctrl <= 4'b0001;
      end else begin
        tx_data <= word_c;
        tx_ctrl <= 4'b0000;
        lfsr_q  <= word_c[6:0];
      end
    end
  end

endmodule

// File: rtl/prbs_frame_chk.sv
module prbs_frame_chk
  import prbs_link_pkg::*;
#(
  parameter int PASS_RUN = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] rx_data,
  input  logic [3:0]  rx_ctrl,
  input  logic        rx_sync,
  output logic        test_pass
);

  localparam int RUN_W = $clog2(PASS_RUN + 1);

  chk_state_t       st_q;
  logic [6:0]       pred_q;
  logic [RUN_W-1:0] run_q;
  logic [31:0]      exp_c;
  logic             is_comma;
  logic             is_data;

  assign exp_c    = prbs7_word32(pred_q);
  assign is_comma = (rx_ctrl == 4'b0001) && (rx_data == {24'h0, K28_5});
  assign is_data  = (rx_ctrl == 4'b0000);

  always_ff @(posedge clk) begin
    if (rst || !rx_sync) begin
      st_q      <= ST_HUNT;
      pred_q    <= '0;
      run_q     <= '0;
      test_pass <= 1'b0;
    end else begin
      unique case (st_q)
        ST_HUNT: begin
          if (is_comma) st_q <= ST_SEED;
        end
        ST_SEED: begin
          if (is_data) begin
            if (rx_data[6:0] != 7'd0) begin
              pred_q <= rx_data[6:0];
              run_q  <= '0;
              st_q   <= ST_CHECK;
            end else begin
              st_q <= ST_HUNT;
            end
          end else if (!is_comma) begin
            st_q <= ST_HUNT;
          end
        end
        ST_CHECK: begin
          if (!is_comma) begin
            pred_q <= exp_c[6:0];
            if (is_data && rx_data == exp_c) begin
              if (run_q >= RUN_W'(PASS_RUN - 1)) test_pass <= 1'b1;
              else                              run_q     <= run_q + 1'b1;
            end else begin
              test_pass <= 1'b0;
              run_q     <= '0;
            end
          end
        end
        default: st_q <= ST_HUNT;
      endcase
    end
  end

endmodule

// File: rtl/prbs_link_tester.sv
module prbs_link_tester #(
  parameter int         FRAME_LEN = 64,
  parameter int         PASS_RUN  = 16,
  parameter logic [6:0] SEED      = 7'h7F
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] tx_data,
  output logic [3:0]  tx_ctrl,
  input  logic [31:0] rx_data,
  input  logic [3:0]  rx_ctrl,
  input  logic        rx_sync,
  output logic        test_pass
);

  prbs_frame_gen #(
    .FRAME_LEN (FRAME_LEN),
    .SEED      (SEED)
  ) u_gen (
    .clk     (clk),
    .rst     (rst),
    .tx_data (tx_data),
    .tx_ctrl (tx_ctrl)
  );

  prbs_frame_chk #(
    .PASS_RUN (PASS_RUN)
  ) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rx_data   (rx_data),
    .rx_ctrl   (rx_ctrl),
    .rx_sync   (rx_sync),
    .test_pass (test_pass)
  );

endmodule

// File: rtl/prbs_link_tester_sva.sv
module prbs_link_tester_sva (
  input logic        clk,
  input logic        rst,
  input logic [31:0] tx_data,
  input logic [3:0]  tx_ctrl,
  input logic        rx_sync,
  input logic        test_pass
);

  assert_comma_fmt_R1: assert property (@(posedge clk) disable iff (rst)
    (tx_ctrl != 4'b0000) |-> (tx_ctrl == 4'b0001 && tx_data == 32'h0000_00BC));

  assert_comma_isolated_R2: assert property (@(posedge clk) disable iff (rst)
    (tx_ctrl != 4'b0000) |=> (tx_ctrl == 4'b0000));

  assert_payload_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
    (tx_ctrl == 4'b0000 && $past(tx_ctrl) != 4'b0000) |-> (tx_data != 32'h0));

  assert_reset_clear_R4: assert property (@(posedge clk)
    rst |=> (!test_pass && tx_ctrl == 4'b0000 && tx_data == 32'h0));

  assert_sync_drop_R9: assert property (@(posedge clk) disable iff (rst)
    !rx_sync |=> !test_pass);

  assert_pass_needs_sync_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(test_pass) |-> $past(rx_sync));

endmodule

bind prbs_link_tester prbs_link_tester_sva u_sva (
  .clk       (clk),
  .rst       (rst),
  .tx_data   (tx_data),
  .tx_ctrl   (tx_ctrl),
  .rx_sync   (rx_sync),
  .test_pass (test_pass)
);

// File: tb/prbs_link_tester_tb.sv
module prbs_link_tester_tb;

  localparam int         CLK_PERIOD = 10;
  localparam int         FRAME_LEN  = 24;
  localparam int         PASS_RUN   = 16;
  localparam logic [6:0] SEED       = 7'h5A;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] tx_data;
  logic [3:0]  tx_ctrl;
  logic [31:0] rx_data;
  logic [3:0]  rx_ctrl;
  logic        rx_sync = 1'b1;
  logic        test_pass;
  logic [31:0] err_mask = '0;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign rx_data = tx_data ^ err_mask;
  assign rx_ctrl = tx_ctrl;

  prbs_link_tester #(
    .FRAME_LEN (FRAME_LEN),
    .PASS_RUN  (PASS_RUN),
    .SEED      (SEED)
  ) u_dut (
    .clk       (clk),
    .rst       (rst),
    .tx_data   (tx_data),
    .tx_ctrl   (tx_ctrl),
    .rx_data   (rx_data),
    .rx_ctrl   (rx_ctrl),
    .rx_sync   (rx_sync),
    .test_pass (test_pass)
  );

  // Bench model: bit-serial PRBS7, x^7 + x^6 + 1, first bit into bit 31.
  task automatic model_word(inout logic [6:0] st, output logic [31:0] w);
    logic fb;
    for (int i = 31; i >= 0; i--) begin
      fb    = st[6] ^ st[5];
      w[i]  = fb;
      st    = {st[5:0], fb};
    end
  endtask

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  task automatic wait_comma();
    do @(negedge clk); while (rx_ctrl != 4'b0001);
  endtask

  // Count payload words starting with the one on the bus now; return on the
  // negedge where the n-th is observed (it is consumed at the next edge).
  task automatic count_payload(input int n);
    int k = 0;
    forever begin
      if (rx_ctrl == 4'b0000) k++;
      if (k >= n) break;
      @(negedge clk);
    end
  endtask

  // After a comma on the bus: seed word, PASS_RUN-1 clean, check low, one more, check high.
  task automatic lock_sequence(input string req);
    @(negedge clk);
    count_payload(PASS_RUN);
    @(negedge clk);
    check(test_pass == 1'b0, req, test_pass, 0);
    count_payload(1);
    @(negedge clk);
    check(test_pass == 1'b1, req, test_pass, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic [6:0]  mst;
    logic [31:0] mw;
    int          bad;
    void'($urandom(32'd1234));
    mst = SEED;

    repeat (3) @(negedge clk);
    // R4: reset state
    check(tx_data == 32'h0 && tx_ctrl == 4'h0, "R4", {tx_ctrl, tx_data}, 0);
    check(test_pass == 1'b0, "R4", test_pass, 0);
    rst = 1'b0;

    // R1 R2 R3: transmitted stream against the model, three frames
    bad = 0;
    for (int w = 0; w < 3 * FRAME_LEN; w++) begin
      @(negedge clk);
      if (w % FRAME_LEN == 0) begin
        if (!(tx_ctrl == 4'b0001 && tx_data == 32'h0000_00BC)) begin
          bad++;
          check(1'b0, "R1/R2 comma", {tx_ctrl, tx_data}, {4'b0001, 32'hBC});
        end
      end else begin
        model_word(mst, mw);
        if (!(tx_ctrl == 4'b0000 && tx_data == mw)) begin
          bad++;
          check(1'b0, "R3 payload", {tx_ctrl, tx_data}, {4'b0000, mw});
        end
      end
    end
    check(bad == 0, "R1 R2 R3 stream", bad, 0);

    // R5 R6: fresh lock after reset
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(test_pass == 1'b0, "R4 reapplied", test_pass, 0);
    rst = 1'b0;
    wait_comma();
    lock_sequence("R5 R6 initial lock");

    // R8: framing words while locked leave the pass flag alone
    bad = 0;
    for (int c = 0; c < 3 * FRAME_LEN; c++) begin
      @(negedge clk);
      if (test_pass != 1'b1) bad++;
    end
    check(bad == 0, "R8 comma skip", bad, 0);

    // R7: random single-bit errors, then recovery by count
    for (int e = 0; e < 6; e++) begin
      repeat (1 + $urandom_range(0, 30)) @(negedge clk);
      while (rx_ctrl != 4'b0000) @(negedge clk);
      err_mask = 32'h1 << $urandom_range(0, 31);
      @(negedge clk);
      err_mask = '0;
      check(test_pass == 1'b0, "R7 mismatch clears", test_pass, 0);
      count_payload(PASS_RUN - 1);
      @(negedge clk);
      check(test_pass == 1'b0, "R7 run restarted", test_pass, 0);
      count_payload(1);
      @(negedge clk);
      check(test_pass == 1'b1, "R7 recovered", test_pass, 1);
    end

    // R9: sync drop, then relock from comma search
    for (int s = 0; s < 4; s++) begin
      repeat ($urandom_range(2, 20)) @(negedge clk);
      rx_sync = 1'b0;
      @(negedge clk);
      check(test_pass == 1'b0, "R9 sync drop", test_pass, 0);
      repeat ($urandom_range(0, 40)) @(negedge clk);
      rx_sync = 1'b1;
      // R5: payload before the comma must not lock the checker
      while (rx_ctrl != 4'b0001) begin
        @(negedge clk);
        if (rx_ctrl == 4'b0000 && test_pass) begin
          check(1'b0, "R5 locked before comma", test_pass, 0);
        end
      end
      check(test_pass == 1'b0, "R5 still hunting", test_pass, 0);
      lock_sequence("R9 relock");
    end

    finish_run();
  end

endmodule